// File: doc/BRIEF.md
# Bit-Serial Column Address Sequencer

This block controls a bit-serial SIMD memory array. Every bit column of every memory block feeds its own processing element. All columns share one word address. The sequencer holds three 16-bit pointers, X, Y and Z. On each cycle it picks one of them to drive the shared memory address, and it broadcasts a small operation code to every processing element, so all columns act on the same word at once.

A start command loads the three pointers with base addresses and gives an operand width N from 1 to 16 bits. The sequencer then runs a serial add, spending three cycles on each bit:

- It reads the operand bit at X.
- It reads the operand bit at Y and adds.
- It writes the sum bit at Z.

After each access, the pointer that was used steps up by one. On the first bit, a clear-carry flag goes out with the first read. When the last write is done, the sequencer raises a one-cycle done pulse. The pointers then hold their final values until the next accepted start.

Top module: `bss_top`

## Requirements
- R1: After reset, busy_o, done_o, mem_we_o and clr_carry_o are 0, pe_op_o is 0 (no operation), and x_o, y_o and z_o are 0.
- R2: A start_i seen at a clock edge while idle, with nbits_i from 1 to 16, is accepted. From the next cycle, busy_o is 1 and x_o, y_o and z_o show the three bases.
- R3: While busy, each bit takes three cycles in a fixed order:
  - read X: pe_op_o = 1, src_sel_o = 0
  - read Y: pe_op_o = 2, src_sel_o = 1
  - write Z: pe_op_o = 3, src_sel_o = 2
- R4: mem_addr_o is the low 10 bits of the pointer chosen by the current cycle. mem_we_o is 1 only in the write-Z cycle. When idle, mem_addr_o is 0.
- R5: Each pointer steps up by one, modulo 2^16, at the edge that ends its own access cycle. X steps after read X, Y after read Y, and Z after write Z.
- R6: busy_o stays high for exactly 3*N cycles. done_o is high for exactly one cycle, the first cycle after busy_o falls.
- R7: clr_carry_o is 1 only in the read-X cycle of the first bit of an operation.
- R8: A start_i that arrives while busy_o is 1 is ignored. The pointers and the operation go on unchanged.
- R9: A start_i with nbits_i equal to 0 or above 16 is ignored. busy_o stays 0 and the pointers keep their values.
- R10: After done, x_o, y_o and z_o hold base+N (modulo 2^16) until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request |
| x_base_i | input | 16 | X base address |
| y_base_i | input | 16 | Y base address |
| z_base_i | input | 16 | Z base address |
| nbits_i | input | 5 | Operand width N (1 to 16) |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mem_addr_o | output | 10 | Shared memory word address |
| mem_we_o | output | 1 | Memory write enable (write-Z cycle) |
| src_sel_o | output | 2 | Pointer driving the address: 0 = X, 1 = Y, 2 = Z |
| pe_op_o | output | 2 | Broadcast operation: 0 = none, 1 = read X, 2 = read Y and add, 3 = write sum |
| clr_carry_o | output | 1 | Clear carry in the processing elements |
| x_o | output | 16 | X pointer |
| y_o | output | 16 | Y pointer |
| z_o | output | 16 | Z pointer |

## Verification
A fault in a pointer shows up on mem_addr_o in the very next cycle that selects that pointer, at most three cycles later. It also persists in the final pointer values after done. A fault in the phase or bit counter changes the pe_op_o and src_sel_o order or the length of busy_o within one bit period. The bench therefore compares every busy cycle against the modelled address, operation and clear-carry values. It also checks the final pointers, including runs that start mid-operation or with an illegal width.

// File: rtl/bss_pkg.sv
package bss_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RDX  = 2'd1,
    PH_RDY  = 2'd2,
    PH_WRZ  = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    SEL_X = 2'd0,
    SEL_Y = 2'd1,
    SEL_Z = 2'd2
  } sel_e;

  localparam int unsigned NUM_PTR = 3;
endpackage

// File: rtl/bss_ptr.sv
module bss_ptr #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] base_i,
  input  logic         inc_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_q <= '0;
    else if (load_i) q_q <= base_i;
    else if (inc_i)  q_q <= q_q + 1'b1;
  end

  assign q_o = q_q;

  // R5: a step adds exactly one, wrapping
  a_r5_post_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !load_i) |=> (q_o == $past(q_o) + 1'b1));
  // R10: the pointer holds without load or step
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !load_i) |=> $stable(q_o));
endmodule

// File: rtl/bss_ctrl.sv
module bss_ctrl
  import bss_pkg::*;
#(
  parameter int unsigned CNT_W    = 5,
  parameter int unsigned MAX_BITS = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] nbits_i,
  output phase_e           phase_o,
  output logic             load_o,
  output logic             inc_x_o,
  output logic             inc_y_o,
  output logic             inc_z_o,
  output logic             first_bit_o,
  output logic             busy_o,
  output logic             done_o
);
  phase_e           phase_q;
  logic             busy_q, done_q;
  logic [CNT_W-1:0] bit_q, n_q;
  logic             accept, last_bit;

  assign accept   = start_i && !busy_q && (nbits_i != '0) &&
                    (nbits_i <= CNT_W'(MAX_BITS));
  assign last_bit = (bit_q == n_q - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      bit_q   <= '0;
      n_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        phase_q <= PH_RDX;
        busy_q  <= 1'b1;
        bit_q   <= '0;
        n_q     <= nbits_i;
      end else if (busy_q) begin
        unique case (phase_q)
          PH_RDX: phase_q <= PH_RDY;
          PH_RDY: phase_q <= PH_WRZ;
          PH_WRZ: begin
            if (last_bit) begin
              phase_q <= PH_IDLE;
              busy_q  <= 1'b0;
              done_q  <= 1'b1;
            end else begin
              phase_q <= PH_RDX;
              bit_q   <= bit_q + 1'b1;
            end
          end
          default: phase_q <= PH_IDLE;
        endcase
      end
    end
  end

  assign phase_o     = phase_q;
  assign load_o      = accept;
  assign inc_x_o     = busy_q && (phase_q == PH_RDX);
  assign inc_y_o     = busy_q && (phase_q == PH_RDY);
  assign inc_z_o     = busy_q && (phase_q == PH_WRZ);
  assign first_bit_o = busy_q && (phase_q == PH_RDX) && (bit_q == '0);
  assign busy_o      = busy_q;
  assign done_o      = done_q;

  // R3: read X is followed by read Y, read Y by write Z
  a_r3_rdx_then_rdy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && phase_q == PH_RDX) |=> (busy_q && phase_q == PH_RDY));
  a_r3_rdy_then_wrz: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && phase_q == PH_RDY) |=> (busy_q && phase_q == PH_WRZ));
  // R6: done follows the fall of busy, for one cycle
  a_r6_done_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> done_q);
  a_r6_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  // R8: the width is not reloaded while busy
  a_r8_no_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !(phase_q == PH_WRZ && last_bit)) |=> $stable(n_q));
endmodule

// File: rtl/bss_issue.sv
module bss_issue
  import bss_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned MEM_AW = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  phase_e            phase_i,
  input  logic              busy_i,
  input  logic              first_bit_i,
  input  logic [ADDR_W-1:0] x_i,
  input  logic [ADDR_W-1:0] y_i,
  input  logic [ADDR_W-1:0] z_i,
  output logic [MEM_AW-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic [1:0]        src_sel_o,
  output logic [1:0]        pe_op_o,
  output logic              clr_carry_o
);
  sel_e              sel;
  logic [ADDR_W-1:0] ptr;

  always_comb begin
    sel = SEL_X;
    ptr = '0;
    if (busy_i) begin
      unique case (phase_i)
        PH_RDY:  begin sel = SEL_Y; ptr = y_i; end
        PH_WRZ:  begin sel = SEL_Z; ptr = z_i; end
        default: begin sel = SEL_X; ptr = x_i; end
      endcase
    end
  end

  assign mem_addr_o  = ptr[MEM_AW-1:0];
  assign mem_we_o    = busy_i && (phase_i == PH_WRZ);
  assign src_sel_o   = sel;
  assign pe_op_o     = busy_i ? phase_i : PH_IDLE;
  assign clr_carry_o = first_bit_i;

  // R4: writes always go to Z
  a_r4_write_at_z: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_addr_o == z_i[MEM_AW-1:0]));
  // R7: clear-carry only with a read of X
  a_r7_clr_on_rdx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_carry_o |-> (busy_i && phase_i == PH_RDX));
endmodule

// File: rtl/bss_top.sv
module bss_top
  import bss_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned MEM_AW   = 10,
  parameter int unsigned MAX_BITS = 16,
  localparam int unsigned CNT_W   = $clog2(MAX_BITS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] x_base_i,
  input  logic [ADDR_W-1:0] y_base_i,
  input  logic [ADDR_W-1:0] z_base_i,
  input  logic [CNT_W-1:0]  nbits_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic [1:0]        src_sel_o,
  output logic [1:0]        pe_op_o,
  output logic              clr_carry_o,
  output logic [ADDR_W-1:0] x_o,
  output logic [ADDR_W-1:0] y_o,
  output logic [ADDR_W-1:0] z_o
);
  phase_e            phase;
  logic              load, first_bit, busy;
  logic [NUM_PTR-1:0] inc;
  logic [ADDR_W-1:0] base [NUM_PTR];
  logic [ADDR_W-1:0] ptr  [NUM_PTR];

  assign base[0] = x_base_i;
  assign base[1] = y_base_i;
  assign base[2] = z_base_i;

  bss_ctrl #(.CNT_W(CNT_W), .MAX_BITS(MAX_BITS)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .nbits_i,
    .phase_o(phase), .load_o(load),
    .inc_x_o(inc[0]), .inc_y_o(inc[1]), .inc_z_o(inc[2]),
    .first_bit_o(first_bit), .busy_o(busy), .done_o
  );

  for (genvar i = 0; i < NUM_PTR; i++) begin : g_ptr
    bss_ptr #(.W(ADDR_W)) u_ptr (
      .clk_i, .rst_ni, .load_i(load), .base_i(base[i]),
      .inc_i(inc[i]), .q_o(ptr[i])
    );
  end

  bss_issue #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW)) u_issue (
    .clk_i, .rst_ni, .phase_i(phase), .busy_i(busy), .first_bit_i(first_bit),
    .x_i(ptr[0]), .y_i(ptr[1]), .z_i(ptr[2]),
    .mem_addr_o, .mem_we_o, .src_sel_o, .pe_op_o, .clr_carry_o
  );

  assign busy_o = busy;
  assign x_o    = ptr[0];
  assign y_o    = ptr[1];
  assign z_o    = ptr[2];

  // R2: accepted start shows the bases next cycle
  a_r2_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> (busy_o && x_o == $past(x_base_i) && z_o == $past(z_base_i)));
endmodule

// File: tb/bss_top_bench.sv
module bss_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] xb = '0, yb = '0, zb = '0;
  logic [4:0]  nb = '0;
  logic        busy, done, we, clr;
  logic [9:0]  addr;
  logic [1:0]  sel, op;
  logic [15:0] xq, yq, zq;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  bss_top u_bss_top (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .x_base_i(xb), .y_base_i(yb), .z_base_i(zb), .nbits_i(nb),
    .busy_o(busy), .done_o(done), .mem_addr_o(addr), .mem_we_o(we),
    .src_sel_o(sel), .pe_op_o(op), .clr_carry_o(clr),
    .x_o(xq), .y_o(yq), .z_o(zq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] exp_addr(input logic [15:0] base, input int bitn);
    logic [15:0] s;
    s = base + 16'(bitn);
    return s[9:0];
  endfunction

  // bench-side final pointer after an N-bit operation
  function automatic logic [15:0] exp_final(input logic [15:0] base, input int n);
    return base + 16'(n);
  endfunction

  // Start at the next edge, then check every busy cycle; optionally inject a stray start.
  task automatic run_op(input logic [15:0] x0, input logic [15:0] y0, input logic [15:0] z0,
                        input int n, input int inject_at);
    @(negedge clk);
    xb = x0; yb = y0; zb = z0; nb = 5'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 x loaded", 32'(xq), 32'(x0));
    chk("R2 y loaded", 32'(yq), 32'(y0));
    chk("R2 z loaded", 32'(zq), 32'(z0));
    for (int k = 0; k < 3 * n; k++) begin
      int ph, bt;
      ph = k % 3;
      bt = k / 3;
      chk("R6 busy", 32'(busy), 32'd1);
      chk("R3 op", 32'(op), 32'(ph + 1));
      chk("R3 sel", 32'(sel), 32'(ph));
      chk("R4 we", 32'(we), 32'(ph == 2));
      chk("R4 addr", 32'(addr),
          32'(exp_addr(ph == 0 ? x0 : (ph == 1 ? y0 : z0), bt)));
      chk("R7 clr", 32'(clr), 32'(k == 0));
      chk("R6 no early done", 32'(done), 32'd0);
      if (k == inject_at) begin
        xb = 16'($urandom); yb = 16'($urandom); zb = 16'($urandom);
        nb = 5'd3; start = 1'b1;  // R8: must be ignored
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    chk("R6 busy low", 32'(busy), 32'd0);
    chk("R6 done pulse", 32'(done), 32'd1);
    chk("R10 x final", 32'(xq), 32'(exp_final(x0, n)));
    chk("R10 y final", 32'(yq), 32'(exp_final(y0, n)));
    chk("R10 z final", 32'(zq), 32'(exp_final(z0, n)));
    @(negedge clk);
    chk("R6 done single", 32'(done), 32'd0);
    chk("R10 x held", 32'(xq), 32'(exp_final(x0, n)));
    chk("R4 idle addr", 32'(addr), 32'd0);
  endtask

  task automatic try_bad(input logic [4:0] n);
    logic [15:0] x_before;
    x_before = xq;
    @(negedge clk);
    xb = 16'h1234; yb = 16'h5678; zb = 16'h9abc; nb = n; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9 stays idle", 32'(busy), 32'd0);
    chk("R9 x unchanged", 32'(xq), 32'(x_before));
    @(negedge clk);
    chk("R9 no done", 32'(done), 32'd0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    #1;
    // R1 reset state
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 done", 32'(done), 32'd0);
    chk("R1 we", 32'(we), 32'd0);
    chk("R1 clr", 32'(clr), 32'd0);
    chk("R1 op", 32'(op), 32'd0);
    chk("R1 ptrs", 32'(xq | yq | zq), 32'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    // directed corners
    run_op(16'h0010, 16'h0020, 16'h0030, 1, -1);
    run_op(16'hfffe, 16'h03ff, 16'h7ffd, 16, -1);  // R5 wrap of 16 bits and of the 10-bit address
    run_op(16'h0100, 16'h0200, 16'h0300, 4, 1);    // R8 stray start mid-op
    try_bad(5'd0);
    try_bad(5'd17);
    try_bad(5'd31);
    for (int i = 0; i < 40; i++) begin
      int n;
      n = 1 + int'($urandom % 16);
      run_op(16'($urandom), 16'($urandom), 16'($urandom), n,
             ($urandom % 3 == 0) ? int'($urandom % (3 * n)) : -1);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule